// File: doc/BRIEF.md
# Ternary Longest-Prefix Route Lookup

This block resolves a 32-bit destination address to a next-hop value by longest-prefix match. It keeps a small table in which every entry has a stored value, a care mask (one bit per address bit: 1 means the bit must match, 0 means either key value is accepted), a next-hop result and a valid flag. All entries are compared with the key at once, and the valid entry that matches and sits at the lowest table index supplies the result.

Control-plane software is expected to load longer prefixes at lower indices than the shorter prefixes that overlap them. Because of that ordering, lowest-index-wins is the same as longest-prefix-wins. No prefix length is stored. A write port loads an entry or clears it. The lookup port takes one key per cycle and answers one cycle later.

Top module: `tcam_lpm`

## Requirements
- R1: After reset, `hit` and `result` are 0 and every entry is invalid, so lookups miss until an entry is loaded.
- R2: A key bit is compared with the stored bit only where the entry's care bit is 1. Where the care bit is 0, the key bit has no effect on the match.
- R3: When several valid entries match the key, the result comes from the matching entry with the lowest index.
- R4: With 128.2.153.0/24 at a lower index than 128.2.0.0/16, the key 128.2.153.x returns the /24 result, and 128.2.y.x with y other than 153 returns the /16 result.
- R5: A lookup that matches no valid entry gives `hit`=0 and `result`=0.
- R6: A write with `wrValid`=0 invalidates the entry at `wrIndex`, and that entry no longer matches any key.
- R7: A key presented with `keyValid` at clock edge k gives `hit` and `result` after edge k. A new key is accepted at every edge.
- R8: A write and a lookup at the same edge: the lookup sees the table as it was before the write. A lookup at the next edge sees the written entry.
- R9: An edge at which `keyValid` is 0 gives `hit`=0 and `result`=0 after that edge.
- R10: An entry whose care mask is all zeros matches every key, and so acts as a default route when it is placed last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the table entry at wrIndex |
| wrIndex | input | $clog2(DEPTH) | Entry index to write; a lower index has higher priority |
| wrValid | input | 1 | 1 loads the entry, 0 invalidates it |
| wrValue | input | KEY_W | Stored value for the entry |
| wrCare | input | KEY_W | Care mask; bit 1 means the key bit must equal the stored bit |
| wrResult | input | RES_W | Next-hop value for the entry |
| keyValid | input | 1 | Lookup strobe |
| key | input | KEY_W | Destination address to look up |
| hit | output | 1 | The previous-cycle lookup matched a valid entry |
| result | output | RES_W | Next-hop value of the winning entry, 0 on a miss |

## Verification
The bench goes after four kinds of corner case.

- **Per-bit sweep.** It flips one key bit at a time against an entry whose care mask is only partly set. A design that inverted the sense of the mask, or compared unmasked bits, would report hits and misses on the wrong bit positions.
- **Stacked prefixes.** It loads several nested prefixes and strips them one at a time from the lowest index. A priority encoder that ran the wrong way would return the shortest prefix. A design whose invalidation leaked would go on returning a cleared entry.
- **Write and lookup together.** It issues a write and a lookup at the same edge. A design that forwarded the write into the search would hit one cycle early.
- **Idle cycles and misses.** An idle or missing cycle must drive `result` to zero. A design that held stale outputs would fail here.

// File: rtl/tcam_lpm_pkg.sv
package tcam_lpm_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic tableWrite;   // update one entry this edge
    logic entryValid;   // value written into the entry's valid flag
    logic search;       // register a lookup result this edge
  } tcamStrobe_t;
endpackage

// File: rtl/tcam_lpm_ctrl.sv
module tcam_lpm_ctrl
  import tcam_lpm_pkg::*;
(
  input  logic        wrEn,
  input  logic        wrValid,
  input  logic        keyValid,
  output tcamStrobe_t strobe
);
  always_comb begin
    strobe.tableWrite = wrEn;
    strobe.entryValid = wrValid;
    strobe.search     = keyValid;
  end
endmodule

// File: rtl/tcam_lpm_dp.sv
module tcam_lpm_dp
  import tcam_lpm_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int KEY_W = 32,
  parameter int RES_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tcamStrobe_t      strobe,
  input  logic [IDX_W-1:0] wrIndex,
  input  logic [KEY_W-1:0] wrValue,
  input  logic [KEY_W-1:0] wrCare,
  input  logic [RES_W-1:0] wrResult,
  input  logic [KEY_W-1:0] key,
  output logic             hit,
  output logic [RES_W-1:0] result
);
  logic [DEPTH-1:0] entryValid;
  logic [KEY_W-1:0] entryValue [DEPTH];
  logic [KEY_W-1:0] entryCare  [DEPTH];
  logic [RES_W-1:0] entryRes   [DEPTH];
  logic [DEPTH-1:0] matchLine;

  // One storage slot and one match line per entry
  for (genvar i = 0; i < DEPTH; i++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entryValid[i] <= 1'b0;
        entryValue[i] <= '0;
        entryCare[i]  <= '0;
        entryRes[i]   <= '0;
      end else if (strobe.tableWrite && (wrIndex == IDX_W'(i))) begin
        entryValid[i] <= strobe.entryValid;
        entryValue[i] <= wrValue & wrCare;
        entryCare[i]  <= wrCare;
        entryRes[i]   <= wrResult;
      end
    end

    assign matchLine[i] = entryValid[i] &&
                          (((key ^ entryValue[i]) & entryCare[i]) == '0);
  end

  // Priority encoder: the lowest matching index wins
  logic             anyMatch;
  logic [IDX_W-1:0] winIdx;
  always_comb begin
    anyMatch = |matchLine;
    winIdx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (matchLine[i]) winIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hit    <= 1'b0;
      result <= '0;
    end else if (strobe.search && anyMatch) begin
      hit    <= 1'b1;
      result <= entryRes[winIdx];
    end else begin
      hit    <= 1'b0;
      result <= '0;
    end
  end
endmodule

// File: rtl/tcam_lpm.sv
module tcam_lpm
  import tcam_lpm_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int KEY_W = 32,
  parameter int RES_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIndex,
  input  logic             wrValid,
  input  logic [KEY_W-1:0] wrValue,
  input  logic [KEY_W-1:0] wrCare,
  input  logic [RES_W-1:0] wrResult,
  input  logic             keyValid,
  input  logic [KEY_W-1:0] key,
  output logic             hit,
  output logic [RES_W-1:0] result
);
  tcamStrobe_t strobe;

  tcam_lpm_ctrl uCtrl (
    .wrEn     (wrEn),
    .wrValid  (wrValid),
    .keyValid (keyValid),
    .strobe   (strobe)
  );

  tcam_lpm_dp #(.DEPTH(DEPTH), .KEY_W(KEY_W), .RES_W(RES_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrIndex  (wrIndex),
    .wrValue  (wrValue),
    .wrCare   (wrCare),
    .wrResult (wrResult),
    .key      (key),
    .hit      (hit),
    .result   (result)
  );
endmodule

// File: rtl/tcam_lpm_checker.sv
module tcam_lpm_checker #(
  parameter int RES_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             wrValid,
  input logic             keyValid,
  input logic             hit,
  input logic [RES_W-1:0] result
);
  // Set once any entry has been loaded since reset
  logic anyLoaded;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) anyLoaded <= 1'b0;
    else if (wrEn && wrValid) anyLoaded <= 1'b1;
  end

  always @(negedge clk) begin
    if (!rstN) begin
      assert_reset_idle_R1: assert (!hit && result == '0)
        else $error("outputs not idle in reset");
    end
  end

  assert_no_hit_empty_R1: assert property (@(posedge clk) disable iff (!rstN)
    !anyLoaded |-> !hit);

  assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (result == '0));

  assert_idle_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    !keyValid |=> (!hit && result == '0));

  assert_hit_needs_key_R7: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> $past(keyValid));
endmodule

bind tcam_lpm tcam_lpm_checker #(.RES_W(RES_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrValid  (wrValid),
  .keyValid (keyValid),
  .hit      (hit),
  .result   (result)
);

// File: tb/tcam_lpm_test.sv
`timescale 1ns/1ps
module tcam_lpm_test;
  localparam int DEPTH = 16;
  localparam int KEY_W = 32;
  localparam int RES_W = 8;
  localparam int IDX_W = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [IDX_W-1:0] wrIndex = '0;
  logic             wrValid = 1'b0;
  logic [KEY_W-1:0] wrValue = '0;
  logic [KEY_W-1:0] wrCare = '0;
  logic [RES_W-1:0] wrResult = '0;
  logic             keyValid = 1'b0;
  logic [KEY_W-1:0] key = '0;
  logic             hit;
  logic [RES_W-1:0] result;

  int checks = 0;
  int errors = 0;

  // Table model built from the requirements
  bit               mValid [DEPTH];
  logic [KEY_W-1:0] mVal   [DEPTH];
  logic [KEY_W-1:0] mCare  [DEPTH];
  logic [RES_W-1:0] mRes   [DEPTH];

  always #2.5 clk = ~clk;

  tcam_lpm #(.DEPTH(DEPTH), .KEY_W(KEY_W), .RES_W(RES_W)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIndex(wrIndex), .wrValid(wrValid),
    .wrValue(wrValue), .wrCare(wrCare), .wrResult(wrResult),
    .keyValid(keyValid), .key(key), .hit(hit), .result(result)
  );

  function automatic logic [KEY_W-1:0] prefixMask(input int len);
    if (len == 0) return '0;
    return {KEY_W{1'b1}} << (KEY_W - len);
  endfunction

  task automatic checkOut(input logic expHit, input logic [RES_W-1:0] expRes,
                          input string req);
    checks++;
    if (hit !== expHit || result !== expRes) begin
      errors++;
      $display("FAIL %s: hit=%0b result=%0d expected hit=%0b result=%0d",
               req, hit, result, expHit, expRes);
    end
  endtask

  // One cycle: drive at negedge, clock, check at the following negedge
  task automatic step(input bit doWr, input int idx, input bit v,
                      input logic [KEY_W-1:0] val, input logic [KEY_W-1:0] care,
                      input logic [RES_W-1:0] res, input bit doKey,
                      input logic [KEY_W-1:0] k, input string req);
    logic             expHit = 1'b0;
    logic [RES_W-1:0] expRes = '0;
    if (doKey) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (mValid[i] && (((k ^ mVal[i]) & mCare[i]) == '0)) begin
          expHit = 1'b1;
          expRes = mRes[i];
          break;
        end
      end
    end
    wrEn = doWr; wrIndex = IDX_W'(idx); wrValid = v;
    wrValue = val; wrCare = care; wrResult = res;
    keyValid = doKey; key = k;
    @(posedge clk);
    if (doWr) begin
      mValid[idx] = v; mVal[idx] = val & care; mCare[idx] = care; mRes[idx] = res;
    end
    @(negedge clk);
    wrEn = 1'b0; keyValid = 1'b0;
    checkOut(expHit, expRes, req);
  endtask

  task automatic load(input int idx, input logic [KEY_W-1:0] val, input int len,
                      input logic [RES_W-1:0] res);
    step(1, idx, 1, val, prefixMask(len), res, 0, '0, "R9");
  endtask

  task automatic look(input logic [KEY_W-1:0] k, input string req);
    step(0, 0, 0, '0, '0, '0, 1, k, req);
  endtask

  task automatic clearAll();
    for (int i = 0; i < DEPTH; i++) step(1, i, 0, '0, '0, '0, 0, '0, "R6");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mValid[i] = 0; mVal[i] = '0; mCare[i] = '0; mRes[i] = '0;
    end
    repeat (3) @(negedge clk);
    checkOut(1'b0, '0, "R1 reset outputs");
    rstN = 1'b1;
    @(negedge clk);
    look(32'h0000_0000, "R1 empty table");
    look(32'hFFFF_FFFF, "R1 empty table");

    // R4: /24 ahead of an overlapping /16
    load(2, 32'h8002_9900, 24, 8'd24);
    load(5, 32'h8002_0000, 16, 8'd16);
    look(32'h8002_994D, "R4 /24 wins");
    look(32'h8002_0701, "R4 /16 only");
    look(32'h0A00_0001, "R5 miss");
    look(32'h8003_9901, "R5 miss");

    // R2: flip each key bit against a partly masked entry
    clearAll();
    step(1, 0, 1, 32'hA5A5_3C3C, 32'hFFFF_0F0F, 8'd7, 0, '0, "R2");
    look(32'hA5A5_3C3C, "R2 exact");
    for (int b = 0; b < KEY_W; b++) look(32'hA5A5_3C3C ^ (32'h1 << b), "R2 bit flip");

    // R10: all-zero care entry as default route
    step(1, 15, 1, 32'h1234_5678, 32'h0, 8'd99, 0, '0, "R10");
    look(32'hDEAD_BEEF, "R10 default");
    look(32'h0000_0000, "R10 default");
    look(32'hA5A5_3C3C, "R3 specific beats default");

    // R3/R6: nested prefixes removed one by one from the lowest index
    clearAll();
    load(3, 32'h0A01_0203, 32, 8'd32);
    load(4, 32'h0A01_0200, 24, 8'd24);
    load(5, 32'h0A01_0000, 16, 8'd16);
    load(6, 32'h0A00_0000, 8, 8'd8);
    look(32'h0A01_0203, "R3 lowest index");
    for (int i = 3; i <= 6; i++) begin
      step(1, i, 0, '0, '0, '0, 0, '0, "R6");
      look(32'h0A01_0203, "R6 after invalidate");
    end

    // R7: back-to-back keys
    load(1, 32'hC0A8_0000, 16, 8'd50);
    load(2, 32'hAC10_0000, 12, 8'd51);
    look(32'hC0A8_0101, "R7 back-to-back");
    look(32'hAC1F_0001, "R7 back-to-back");
    look(32'h0808_0808, "R7 back-to-back");
    look(32'hC0A8_FFFF, "R7 back-to-back");

    // R8: write and lookup at the same edge
    step(1, 0, 1, 32'h0808_0800, prefixMask(24), 8'd77, 1, 32'h0808_0808, "R8 old contents");
    look(32'h0808_0808, "R8 new contents");
    step(1, 0, 0, '0, '0, '0, 1, 32'h0808_0808, "R8 invalidate same edge");
    look(32'h0808_0808, "R8 after invalidate");

    // R9: idle cycle after a hit
    look(32'hC0A8_0001, "R9 hit");
    step(0, 0, 0, '0, '0, '0, 0, 32'hC0A8_0001, "R9 idle clears");

    // R3: pseudo-random mix against the model
    for (int n = 0; n < 400; n++) begin
      int idx = $urandom_range(DEPTH - 1);
      int len = $urandom_range(32);
      bit doWr = ($urandom_range(3) == 0);
      logic [KEY_W-1:0] k = mVal[$urandom_range(DEPTH - 1)] ^ KEY_W'($urandom_range(255));
      if ($urandom_range(7) == 0) k = $urandom;
      step(doWr, idx, $urandom_range(4) != 0, $urandom, prefixMask(len),
           RES_W'($urandom), $urandom_range(5) != 0, k, "R3 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule